// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a single-data-rate SDRAM interface. At every rising clock edge it samples the control strobes, the clock-enable, the bank address, the address bus and the data mask. It turns that pin pattern into one decoded command and keeps a small state record for each of the four banks: whether a row is open, which row it is, and whether that row is closing under auto-precharge.

All decoded results are registered. They appear after the edge that sampled the command. The outputs are the command code, the target bank, the row or column, the precharge kind, the refresh strobes, a mode-load strobe with its op-code, and two flags. One flag marks illegal commands and the other marks protocol errors. The block also gives two versions of the mask: one for write data with no delay, and one for read data delayed so it lines up with the read burst. The memory array, the data path and refresh row counting are handled by neighbouring blocks.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When `cs_n` is high, the command is an inhibit. `cmd_o` reads 0 (NOP), no strobe fires and no bank state changes, whatever the other pins carry.
- R2: After reset every output is 0. A command sampled at one edge is reported after that same edge. Pin patterns with `cs_n` low, given as {ras_n,cas_n,we_n}, map to these `cmd_o` codes: 111 NOP=0, 011 ACTIVE=1, 101 READ=2, 100 WRITE=3, 110 burst stop=4, 010 PRECHARGE=5, 001 with cke high auto refresh=6, 001 with cke low self refresh=7, 000 mode load=8.
- R3: ACTIVE to an idle bank opens the 13-bit row on `addr` in bank `ba`. It sets `bank_active_o[ba]` and reports that row on `row_o`. A later READ or WRITE to that bank reports the same row on `row_o`.
- R4: For READ and WRITE, `col_o` takes its bits from `addr` according to `ORG`. With 16 it is addr[9:0]; with 8 it is {addr[11],addr[9:0]}; with 4 it is {addr[12:11],addr[9:0]}. For any other command `col_o` is 0.
- R5: A valid READ or WRITE with addr[10] high raises `auto_pre_o` and sets `ap_pend_o[ba]`. The bank then goes idle, and its pending bit clears, on the `AP_CYC`-th edge after the access.
- R6: PRECHARGE with addr[10] low closes bank `ba` only. With addr[10] high it closes every bank, ignores `ba` and raises `pre_all_o`. Precharge also clears pending flags.
- R7: The refresh pattern raises `aref_o` when cke is high and `sref_o` when cke is low, but only if all banks are idle. If any bank is active, the refresh raises `illegal_o` and neither strobe fires.
- R8: Mode load with addr[12] low pulses `mode_load_o` and latches addr[11:0] onto `mode_op_o`. With addr[12] high it raises `illegal_o`, gives no pulse and leaves `mode_op_o` unchanged.
- R9: With cke low, a command that has `cs_n` low and is neither NOP nor refresh raises `illegal_o`. It reports `cmd_o`=0 and changes no bank state.
- R10: `proto_err_o` is raised in three cases: a READ or WRITE to an idle bank, a READ or WRITE to a bank whose row is closing, and an ACTIVE to an active bank. The command causes no open and no auto-precharge.
- R11: `wr_mask_o` follows `dqm` with no delay. `rd_mask_o` equals the `dqm` value sampled two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus |
| dqm | input | DQM_W | Data mask |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Target bank |
| row_o | output | 13 | Row opened or row being accessed |
| col_o | output | COL_W | Column of a READ or WRITE |
| auto_pre_o | output | 1 | Access requested auto-precharge |
| pre_all_o | output | 1 | Precharge of all banks |
| aref_o | output | 1 | Auto refresh request |
| sref_o | output | 1 | Self refresh entry |
| mode_load_o | output | 1 | Mode register load strobe |
| mode_op_o | output | 12 | Last loaded op-code |
| illegal_o | output | 1 | Illegal command flag |
| proto_err_o | output | 1 | Bank protocol error flag |
| bank_active_o | output | 4 | Per-bank open flags |
| ap_pend_o | output | 4 | Per-bank auto-precharge pending flags |
| wr_mask_o | output | DQM_W | Write data mask, no delay |
| rd_mask_o | output | DQM_W | Read output mask, two-edge delay |

## Verification
The assertions assume that every input is a defined 0 or 1 at each sampled edge. They also assume that `AP_CYC` is at least 1, so that a pending flag is visible after the access that set it. The bench holds every input steady from one falling edge to the next. It drives a command on every cycle, NOPs included, so that the mask delay and the auto-precharge countdown advance exactly once per command slot. It varies `dqm` from one command to the next so that a wrong read-mask depth shows up.

// File: rtl/sdtrk_pkg.sv
package sdtrk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_BST  = 4'd4,
        CMD_PRE  = 4'd5,
        CMD_AREF = 4'd6,
        CMD_SREF = 4'd7,
        CMD_LMR  = 4'd8
    } cmd_e;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 2;
    localparam int ADDR_W    = 13;
    localparam int OP_W      = 12;

    function automatic int col_width(input int org);
        if (org == 16) return 10;
        else if (org == 8) return 11;
        else return 12;
    endfunction

    function automatic logic [11:0] pick_col(input logic [ADDR_W-1:0] a, input int org);
        if (org == 16) return {2'b00, a[9:0]};
        else if (org == 8) return {1'b0, a[11], a[9:0]};
        else return {a[12:11], a[9:0]};
    endfunction

endpackage

// File: rtl/sdtrk_decode.sv
module sdtrk_decode
    import sdtrk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output cmd_e cmd,
    output logic cke_viol
);
    logic [2:0] pins;
    assign pins = {ras_n, cas_n, we_n};

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case (pins)
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                3'b000:  cmd = CMD_LMR;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    assign cke_viol = !cs_n && !cke && (pins != 3'b111) && (pins != 3'b001);
endmodule

// File: rtl/sdtrk_bank.sv
module sdtrk_bank #(
    parameter int ROW_W  = 13,
    parameter int AP_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic             close_i,
    input  logic             ap_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             active_o,
    output logic             pend_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int CW = $clog2(AP_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            pend_o   <= 1'b0;
            cnt      <= '0;
            row_o    <= '0;
        end else if (close_i) begin
            active_o <= 1'b0;
            pend_o   <= 1'b0;
            cnt      <= '0;
        end else begin
            if (open_i) begin
                active_o <= 1'b1;
                row_o    <= row_i;
            end
            if (ap_i) begin
                pend_o <= 1'b1;
                cnt    <= CW'(AP_CYC);
            end else if (pend_o) begin
                if (cnt == CW'(1)) begin
                    active_o <= 1'b0;
                    pend_o   <= 1'b0;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sdtrk_mask.sv
module sdtrk_mask #(
    parameter int W     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) st[i] <= '0;
        end else begin
            st[0] <= din;
            for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
        end
    end

    assign dout = st[DEPTH-1];
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdtrk_pkg::*;
#(
    parameter int ORG         = 16,
    parameter int AP_CYC      = 3,
    parameter int DQM_W       = 2,
    parameter int RD_MASK_LAT = 2,
    localparam int COL_W      = col_width(ORG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke,
    input  logic [BANK_W-1:0]    ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DQM_W-1:0]     dqm,
    output logic [3:0]           cmd_o,
    output logic [BANK_W-1:0]    bank_o,
    output logic [ADDR_W-1:0]    row_o,
    output logic [COL_W-1:0]     col_o,
    output logic                 auto_pre_o,
    output logic                 pre_all_o,
    output logic                 aref_o,
    output logic                 sref_o,
    output logic                 mode_load_o,
    output logic [OP_W-1:0]      mode_op_o,
    output logic                 illegal_o,
    output logic                 proto_err_o,
    output logic [NUM_BANKS-1:0] bank_active_o,
    output logic [NUM_BANKS-1:0] ap_pend_o,
    output logic [DQM_W-1:0]     wr_mask_o,
    output logic [DQM_W-1:0]     rd_mask_o
);
    cmd_e raw, eff;
    logic cke_viol, ok, is_acc, is_ref, any_act, tgt_act, tgt_pend;
    logic proto, illegal, ap_req, pre_all, load;
    logic [11:0] col_full;
    logic [NUM_BANKS-1:0] open_v, close_v, ap_v;
    logic [ADDR_W-1:0] rows [NUM_BANKS];

    sdtrk_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .cmd(raw), .cke_viol(cke_viol)
    );

    assign ok       = !cke_viol;
    assign eff      = cke_viol ? CMD_NOP : raw;
    assign is_acc   = (eff == CMD_RD) || (eff == CMD_WR);
    assign is_ref   = (eff == CMD_AREF) || (eff == CMD_SREF);
    assign any_act  = |bank_active_o;
    assign tgt_act  = bank_active_o[ba];
    assign tgt_pend = ap_pend_o[ba];
    assign proto    = (is_acc && (!tgt_act || tgt_pend)) || (eff == CMD_ACT && tgt_act);
    assign illegal  = cke_viol || (is_ref && any_act) || (eff == CMD_LMR && addr[12]);
    assign ap_req   = is_acc && !proto && addr[10];
    assign pre_all  = (eff == CMD_PRE) && addr[10];
    assign load     = (eff == CMD_LMR) && !addr[12];
    assign col_full = pick_col(addr, ORG);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign open_v[b]  = ok && eff == CMD_ACT && !tgt_act && ba == BANK_W'(b);
        assign close_v[b] = ok && eff == CMD_PRE && (addr[10] || ba == BANK_W'(b));
        assign ap_v[b]    = ap_req && ba == BANK_W'(b);

        sdtrk_bank #(.ROW_W(ADDR_W), .AP_CYC(AP_CYC)) u_bank (
            .clk(clk), .rst(rst),
            .open_i(open_v[b]), .close_i(close_v[b]), .ap_i(ap_v[b]),
            .row_i(addr),
            .active_o(bank_active_o[b]), .pend_o(ap_pend_o[b]), .row_o(rows[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o       <= '0;
            bank_o      <= '0;
            row_o       <= '0;
            col_o       <= '0;
            auto_pre_o  <= 1'b0;
            pre_all_o   <= 1'b0;
            aref_o      <= 1'b0;
            sref_o      <= 1'b0;
            mode_load_o <= 1'b0;
            mode_op_o   <= '0;
            illegal_o   <= 1'b0;
            proto_err_o <= 1'b0;
        end else begin
            cmd_o       <= eff;
            bank_o      <= ba;
            row_o       <= (eff == CMD_ACT) ? addr : (is_acc ? rows[ba] : '0);
            col_o       <= is_acc ? col_full[COL_W-1:0] : '0;
            auto_pre_o  <= ap_req;
            pre_all_o   <= pre_all;
            aref_o      <= (eff == CMD_AREF) && !any_act;
            sref_o      <= (eff == CMD_SREF) && !any_act;
            mode_load_o <= load;
            if (load) mode_op_o <= addr[OP_W-1:0];
            illegal_o   <= illegal;
            proto_err_o <= proto;
        end
    end

    assign wr_mask_o = dqm;

    sdtrk_mask #(.W(DQM_W), .DEPTH(RD_MASK_LAT)) u_rdmask (
        .clk(clk), .rst(rst), .din(dqm), .dout(rd_mask_o)
    );
endmodule

// File: rtl/sdtrk_chk.sv
module sdtrk_chk #(
    parameter int DQM_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             cke,
    input logic [DQM_W-1:0] dqm,
    input logic [3:0]       cmd_o,
    input logic [1:0]       bank_o,
    input logic             auto_pre_o,
    input logic             pre_all_o,
    input logic             aref_o,
    input logic             sref_o,
    input logic             mode_load_o,
    input logic             illegal_o,
    input logic             proto_err_o,
    input logic [3:0]       bank_active_o,
    input logic [3:0]       ap_pend_o,
    input logic [DQM_W-1:0] rd_mask_o
);
    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R1
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_o == 4'd0 && !mode_load_o && !aref_o && !sref_o));

    // R5
    ap_pending_chk: assert property (@(posedge clk) disable iff (rst)
        auto_pre_o |-> ap_pend_o[bank_o]);

    // R6
    pre_all_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pre_all_o |-> (bank_active_o == 4'd0 && ap_pend_o == 4'd0));

    // R7
    refresh_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (aref_o || sref_o) |-> (bank_active_o == 4'd0 && !illegal_o));

    // R7
    sref_cke_chk: assert property (@(posedge clk) disable iff (rst)
        sref_o |-> !$past(cke));

    // R8
    load_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode_load_o |-> !illegal_o);

    // R10
    proto_no_ap_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |-> !auto_pre_o);

    // R11
    rd_mask_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (rd_mask_o == $past(dqm, 2)));
endmodule

bind sdram_cmd_tracker sdtrk_chk #(.DQM_W(DQM_W)) u_chk (.*);

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;
    localparam int AP = 3;

    typedef struct {
        logic [3:0]  cmd;
        logic [1:0]  bank;
        logic [12:0] row;
        logic [9:0]  col;
        logic        ap, pall, aref, sref, mload, ill, prot;
        logic [11:0] mop;
        logic [3:0]  act, pend;
        logic [1:0]  rdm;
        string       tag;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0] ba = '0;
    logic [12:0] addr = '0;
    logic [1:0] dqm = '0;
    logic [3:0] cmd_o;
    logic [1:0] bank_o;
    logic [12:0] row_o;
    logic [9:0] col_o;
    logic auto_pre_o, pre_all_o, aref_o, sref_o, mode_load_o, illegal_o, proto_err_o;
    logic [11:0] mode_op_o;
    logic [3:0] bank_active_o, ap_pend_o;
    logic [1:0] wr_mask_o, rd_mask_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    exp_t sb [$];

    logic [3:0] m_act = '0, m_pend = '0;
    int m_cnt [4] = '{0, 0, 0, 0};
    logic [12:0] m_row [4] = '{13'd0, 13'd0, 13'd0, 13'd0};
    logic [11:0] m_op = '0;
    logic [1:0] m_st0 = '0;

    always #5 clk = ~clk;

    sdram_cmd_tracker #(.ORG(16), .AP_CYC(AP), .DQM_W(2), .RD_MASK_LAT(2)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .addr(addr), .dqm(dqm), .cmd_o(cmd_o), .bank_o(bank_o),
        .row_o(row_o), .col_o(col_o), .auto_pre_o(auto_pre_o), .pre_all_o(pre_all_o),
        .aref_o(aref_o), .sref_o(sref_o), .mode_load_o(mode_load_o), .mode_op_o(mode_op_o),
        .illegal_o(illegal_o), .proto_err_o(proto_err_o), .bank_active_o(bank_active_o),
        .ap_pend_o(ap_pend_o), .wr_mask_o(wr_mask_o), .rd_mask_o(rd_mask_o)
    );

    task automatic chk(input bit good, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic [2:0] p, input logic k,
                         input logic [1:0] b, input logic [12:0] a,
                         input logic [1:0] m, input string tag);
        exp_t e;
        logic [3:0] raw;
        logic viol, ok, acc, anyact, nact, npend;
        @(negedge clk);
        cs_n = c; {ras_n, cas_n, we_n} = p; cke = k; ba = b; addr = a; dqm = m;
        #1;
        chk(wr_mask_o == m, "R11", "wr_mask", wr_mask_o, m);
        raw = 4'd0;
        if (!c) begin
            case (p)
                3'b011: raw = 4'd1;
                3'b101: raw = 4'd2;
                3'b100: raw = 4'd3;
                3'b110: raw = 4'd4;
                3'b010: raw = 4'd5;
                3'b001: raw = k ? 4'd6 : 4'd7;
                3'b000: raw = 4'd8;
                default: raw = 4'd0;
            endcase
        end
        viol = !c && !k && p != 3'b111 && p != 3'b001;
        ok = !viol;
        if (viol) raw = 4'd0;
        acc = raw == 4'd2 || raw == 4'd3;
        anyact = |m_act;
        e.tag = tag;
        e.cmd = raw;
        e.bank = b;
        e.prot = (acc && (!m_act[b] || m_pend[b])) || (raw == 4'd1 && m_act[b]);
        e.ill = viol || ((raw == 4'd6 || raw == 4'd7) && anyact) || (raw == 4'd8 && a[12]);
        e.row = (raw == 4'd1) ? a : (acc ? m_row[b] : 13'd0);
        e.col = acc ? a[9:0] : 10'd0;
        e.ap = acc && !e.prot && a[10];
        e.pall = raw == 4'd5 && a[10];
        e.aref = raw == 4'd6 && !anyact;
        e.sref = raw == 4'd7 && !anyact;
        e.mload = raw == 4'd8 && !a[12];
        if (e.mload) m_op = a[11:0];
        e.mop = m_op;
        e.rdm = m_st0;
        m_st0 = m;
        for (int i = 0; i < 4; i++) begin
            nact = m_act[i];
            npend = m_pend[i];
            if (ok && raw == 4'd5 && (a[10] || b == 2'(i))) begin
                nact = 0; npend = 0; m_cnt[i] = 0;
            end else begin
                if (ok && raw == 4'd1 && !m_act[b] && b == 2'(i)) begin
                    nact = 1; m_row[i] = a;
                end
                if (e.ap && b == 2'(i)) begin
                    npend = 1; m_cnt[i] = AP;
                end else if (m_pend[i]) begin
                    if (m_cnt[i] == 1) begin
                        nact = 0; npend = 0; m_cnt[i] = 0;
                    end else m_cnt[i]--;
                end
            end
            e.act[i] = nact;
            e.pend[i] = npend;
        end
        m_act = e.act;
        m_pend = e.pend;
        sb.push_back(e);
    endtask

    task automatic nop(input logic [1:0] m, input string tag);
        drive(1'b0, 3'b111, 1'b1, 2'd0, 13'd0, m, tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(cmd_o == e.cmd, e.tag, "cmd", cmd_o, e.cmd);
            chk(bank_o == e.bank, e.tag, "bank", bank_o, e.bank);
            chk(row_o == e.row, e.tag, "row", row_o, e.row);
            chk(col_o == e.col, e.tag, "col", col_o, e.col);
            chk(auto_pre_o == e.ap, e.tag, "auto_pre", auto_pre_o, e.ap);
            chk(pre_all_o == e.pall, e.tag, "pre_all", pre_all_o, e.pall);
            chk(aref_o == e.aref, e.tag, "aref", aref_o, e.aref);
            chk(sref_o == e.sref, e.tag, "sref", sref_o, e.sref);
            chk(mode_load_o == e.mload, e.tag, "mode_load", mode_load_o, e.mload);
            chk(mode_op_o == e.mop, e.tag, "mode_op", mode_op_o, e.mop);
            chk(illegal_o == e.ill, e.tag, "illegal", illegal_o, e.ill);
            chk(proto_err_o == e.prot, e.tag, "proto_err", proto_err_o, e.prot);
            chk(bank_active_o == e.act, e.tag, "bank_active", bank_active_o, e.act);
            chk(ap_pend_o == e.pend, e.tag, "ap_pend", ap_pend_o, e.pend);
            chk(rd_mask_o == e.rdm, "R11", "rd_mask", rd_mask_o, e.rdm);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 reset state
        chk({cmd_o, row_o, col_o, mode_op_o, bank_active_o, ap_pend_o, rd_mask_o} == '0 &&
            !illegal_o && !proto_err_o && !mode_load_o, "R2", "reset outputs",
            {cmd_o, bank_active_o}, 0);
        rst = 1'b0;
        // R1 inhibit carrying a mode-load pattern
        drive(1'b1, 3'b000, 1'b1, 2'd3, 13'h0FFF, 2'b01, "R1");
        drive(1'b1, 3'b011, 1'b1, 2'd1, 13'h0AAA, 2'b10, "R1");
        // R2 encodings
        nop(2'b11, "R2");
        drive(1'b0, 3'b110, 1'b1, 2'd0, 13'd0, 2'b00, "R2");
        // R3 open rows
        drive(1'b0, 3'b011, 1'b1, 2'd1, 13'h1ABC, 2'b01, "R3");
        drive(1'b0, 3'b011, 1'b1, 2'd2, 13'h0123, 2'b10, "R3");
        // R4 column on x16 ignores A11/A12
        drive(1'b0, 3'b101, 1'b1, 2'd1, 13'h1BFF, 2'b11, "R4");
        drive(1'b0, 3'b100, 1'b1, 2'd1, 13'h0155, 2'b00, "R4");
        // R10 protocol errors
        drive(1'b0, 3'b101, 1'b1, 2'd0, 13'h0010, 2'b01, "R10");
        drive(1'b0, 3'b011, 1'b1, 2'd1, 13'h0777, 2'b10, "R10");
        // R5 auto-precharge then closing bank
        drive(1'b0, 3'b100, 1'b1, 2'd2, 13'h0405, 2'b11, "R5");
        drive(1'b0, 3'b101, 1'b1, 2'd2, 13'h0006, 2'b00, "R10");
        nop(2'b01, "R5");
        nop(2'b10, "R5");
        nop(2'b00, "R5");
        // R6 single and all-bank precharge
        drive(1'b0, 3'b010, 1'b1, 2'd1, 13'h0000, 2'b01, "R6");
        drive(1'b0, 3'b011, 1'b1, 2'd0, 13'h0042, 2'b10, "R6");
        drive(1'b0, 3'b011, 1'b1, 2'd3, 13'h1F00, 2'b11, "R6");
        drive(1'b0, 3'b010, 1'b1, 2'd1, 13'h0400, 2'b00, "R6");
        // R7 refresh
        drive(1'b0, 3'b001, 1'b1, 2'd2, 13'h1234, 2'b01, "R7");
        drive(1'b0, 3'b011, 1'b1, 2'd0, 13'h0009, 2'b10, "R7");
        drive(1'b0, 3'b001, 1'b1, 2'd0, 13'h0000, 2'b11, "R7");
        drive(1'b0, 3'b010, 1'b1, 2'd0, 13'h0400, 2'b00, "R7");
        drive(1'b0, 3'b001, 1'b0, 2'd0, 13'h0000, 2'b01, "R7");
        // R9 commands with cke low
        drive(1'b0, 3'b011, 1'b0, 2'd2, 13'h0333, 2'b10, "R9");
        drive(1'b0, 3'b000, 1'b0, 2'd0, 13'h0055, 2'b11, "R9");
        drive(1'b0, 3'b111, 1'b0, 2'd0, 13'h0000, 2'b00, "R9");
        nop(2'b01, "R9");
        // R8 mode load
        drive(1'b0, 3'b000, 1'b1, 2'd0, 13'h0033, 2'b10, "R8");
        drive(1'b0, 3'b000, 1'b1, 2'd0, 13'h1027, 2'b11, "R8");
        // R5 with read and a full countdown, then R11 flush
        drive(1'b0, 3'b011, 1'b1, 2'd3, 13'h0101, 2'b00, "R5");
        drive(1'b0, 3'b101, 1'b1, 2'd3, 13'h0488, 2'b01, "R5");
        for (int i = 0; i < 4; i++) nop(2'(i), "R11");
        @(posedge clk);
        #2;
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule